// File: doc/BRIEF.md
# Nibble ALU with Flags

This block is the 4-bit arithmetic unit of a nibble-wide controller. Each accepted operation takes two 4-bit operands, an operation code and a three-bit flag write mask. It produces a 4-bit result and updates a carry flag (CF), a zero flag (ZF) and a status flag (SF), which is used as the branch condition. Subtraction treats CF as an inverted borrow: CF is 1 when no borrow was needed. Two carry-test operations copy CF into SF and then clear or set CF.

Operations arrive on a valid/ready input and leave through a one-entry output register with valid/ready. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that cycle, so back-pressure on `out_ready` stalls the input. Result and flags become visible on the edge that accepts the operation. The flag register is always visible on `flags_out`, so an interrupt sequencer saves it from there. On return it writes the flags back through `restore_en`/`restore_flags`.

Top module: `nibble_alu`

## Requirements
- R1: After reset, flags_out is SF=1, ZF=0, CF=0, and out_valid is 0. Flag vectors are {SF,ZF,CF}, so SF is bit 2, ZF is bit 1 and CF is bit 0. Mask bits use the same positions.
- R2: ADD (code 0) returns a+b modulo 16. Its CF value is the carry-out and its SF value is the inverse of the carry-out.
- R3: ADC (code 1) returns a+b+CF modulo 16, using the flag register as it stands at acceptance. Its CF value is the carry-out and its SF value is the inverse of the carry-out.
- R4: SUB (code 2) returns a-b modulo 16. Its CF value and its SF value are both 1 when a>=b (no borrow) and 0 otherwise.
- R5: SBC (code 3) returns a-b-(1-CF) modulo 16. Its CF value and its SF value are 1 when no borrow results.
- R6: CMP (code 4) returns operand a unchanged. Its CF and SF values are those of SUB, and its ZF value is 1 when a equals b.
- R7: For codes 0-3 and 5-8, the ZF value is 1 exactly when the returned result is zero.
- R8: RLC (code 5) returns {a[2:0],CF}, with CF value a[3]. RRC (code 6) returns {CF,a[3:1]}, with CF value a[0]. Both have SF value 1.
- R9: TCLR (code 7) and TSET (code 8) return a. Their SF value is the old CF. Their CF value is 0 for TCLR and 1 for TSET.
- R10: Only the flags whose mask bit is 1 are written. Flags whose mask bit is 0 keep their previous value.
- R11: Codes 9 to 15 return operand a and leave all flags unchanged, whatever the mask.
- R12: in_ready equals !out_valid || out_ready. While out_valid=1 and out_ready=0, res_data is held and no new operation is accepted.
- R13: restore_en loads restore_flags into the flag register on the next edge. If an operation is accepted on the same edge, the restore takes priority over that operation's flag writes, and the operation's result is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Operation can be accepted |
| op_code | input | 4 | Operation code |
| opnd_a | input | 4 | First operand (accumulator side) |
| opnd_b | input | 4 | Second operand |
| flag_mask | input | 3 | Write enables {SF,ZF,CF} |
| restore_en | input | 1 | Load restore_flags into the flag register |
| restore_flags | input | 3 | Flags to restore {SF,ZF,CF} |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| res_data | output | 4 | Result |
| flags_out | output | 3 | Current flag register {SF,ZF,CF} |

## Verification
The bench targets the inverted-borrow rule at its edges. Cases include 9-9 and 7-F, and SBC with and without an incoming borrow. A design that used a plain borrow polarity would flip CF in every one of these cases. Masked add-immediate style updates (8+D and 3+5) leave CF alone; a design that ignored the mask would corrupt the carry chain. Rotates and carry tests are checked for the direction of the bit through CF. Further checks cover a stalled output, a restore colliding with an operation, and reserved codes with a full mask. A design wrong in any of these would drop results, apply stale flags or write flags it should not touch.

// File: rtl/nalu_pkg.sv
package nalu_pkg;
  localparam int FLAG_W = 3;
  localparam int CF_B   = 0;
  localparam int ZF_B   = 1;
  localparam int SF_B   = 2;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_RLC  = 4'd5,
    OP_RRC  = 4'd6,
    OP_TCLR = 4'd7,
    OP_TSET = 4'd8
  } alu_op_e;
endpackage

// File: rtl/nalu_core.sv
module nalu_core
  import nalu_pkg::*;
#(
  parameter int DW = 4
) (
  input  alu_op_e           op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic [FLAG_W-1:0] mask,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [DW-1:0]     res,
  output logic [FLAG_W-1:0] cand,
  output logic [FLAG_W-1:0] wmask
);
  localparam int EW = DW + 1;

  logic [EW-1:0] ext_a, ext_b, cin_ext, bin_ext, sum, diff;
  logic          cf_in, no_borrow;

  always_comb begin
    cf_in   = flags_in[CF_B];
    ext_a   = {1'b0, a};
    ext_b   = {1'b0, b};
    cin_ext = {{DW{1'b0}}, (op == OP_ADC) ? cf_in : 1'b0};
    bin_ext = {{DW{1'b0}}, (op == OP_SBC) ? ~cf_in : 1'b0};
    sum     = ext_a + ext_b + cin_ext;
    diff    = ext_a - ext_b - bin_ext;
    no_borrow = ~diff[DW];

    res   = a;
    cand  = flags_in;
    wmask = mask;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res        = sum[DW-1:0];
        cand[CF_B] = sum[DW];
        cand[SF_B] = ~sum[DW];
        cand[ZF_B] = (sum[DW-1:0] == '0);
      end
      OP_SUB, OP_SBC: begin
        res        = diff[DW-1:0];
        cand[CF_B] = no_borrow;
        cand[SF_B] = no_borrow;
        cand[ZF_B] = (diff[DW-1:0] == '0);
      end
      OP_CMP: begin
        res        = a;
        cand[CF_B] = no_borrow;
        cand[SF_B] = no_borrow;
        cand[ZF_B] = (diff[DW-1:0] == '0);
      end
      OP_RLC: begin
        res        = {a[DW-2:0], cf_in};
        cand[CF_B] = a[DW-1];
        cand[SF_B] = 1'b1;
        cand[ZF_B] = ({a[DW-2:0], cf_in} == '0);
      end
      OP_RRC: begin
        res        = {cf_in, a[DW-1:1]};
        cand[CF_B] = a[0];
        cand[SF_B] = 1'b1;
        cand[ZF_B] = ({cf_in, a[DW-1:1]} == '0);
      end
      OP_TCLR, OP_TSET: begin
        res        = a;
        cand[SF_B] = cf_in;
        cand[CF_B] = (op == OP_TSET);
        cand[ZF_B] = (a == '0);
      end
      default: begin
        res   = a;
        wmask = '0;
      end
    endcase
  end
endmodule

// File: rtl/nalu_flags.sv
module nalu_flags
  import nalu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [FLAG_W-1:0] wmask,
  input  logic [FLAG_W-1:0] cand,
  input  logic              restore_en,
  input  logic [FLAG_W-1:0] restore_val,
  output logic [FLAG_W-1:0] flags_q
);
  localparam logic [FLAG_W-1:0] RST_FLAGS = FLAG_W'(1) << SF_B;

  logic [FLAG_W-1:0] nxt;

  always_comb begin
    nxt = flags_q;
    if (restore_en) begin
      nxt = restore_val;
    end else if (upd_en) begin
      for (int i = 0; i < FLAG_W; i++) begin
        if (wmask[i]) nxt[i] = cand[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= RST_FLAGS;
    else        flags_q <= nxt;
  end

  // R13
  restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> flags_q == $past(restore_val));

  // R10
  cf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !restore_en && !wmask[CF_B]) |=> flags_q[CF_B] == $past(flags_q[CF_B]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !restore_en) |=> $stable(flags_q));
endmodule

// File: rtl/nalu_stage.sv
module nalu_stage #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] res_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] res_q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      res_q     <= res_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_q)));
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import nalu_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        op_code,
  input  logic [DW-1:0]     opnd_a,
  input  logic [DW-1:0]     opnd_b,
  input  logic [FLAG_W-1:0] flag_mask,
  input  logic              restore_en,
  input  logic [FLAG_W-1:0] restore_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     res_data,
  output logic [FLAG_W-1:0] flags_out
);
  alu_op_e           op;
  logic [DW-1:0]     core_res;
  logic [FLAG_W-1:0] cand, wmask;
  logic              accept;

  assign op     = alu_op_e'(op_code);
  assign accept = in_valid && in_ready;

  nalu_core #(.DW(DW)) core_i (
    .op(op), .a(opnd_a), .b(opnd_b), .mask(flag_mask),
    .flags_in(flags_out), .res(core_res), .cand(cand), .wmask(wmask)
  );

  nalu_flags flags_i (
    .clk(clk), .rst_n(rst_n), .upd_en(accept), .wmask(wmask), .cand(cand),
    .restore_en(restore_en), .restore_val(restore_flags), .flags_q(flags_out)
  );

  nalu_stage #(.DW(DW)) stage_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .res_in(core_res), .out_valid(out_valid), .out_ready(out_ready), .res_q(res_data)
  );

  // R9
  tclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !restore_en && op_code == 4'd7 && flag_mask[CF_B]) |=> !flags_out[CF_B]);

  // R11
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !restore_en && op_code > 4'd8) |=> $stable(flags_out));
endmodule

// File: tb/nibble_alu_tb.sv
module nibble_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] op_code = '0;
  logic [3:0] opnd_a = '0;
  logic [3:0] opnd_b = '0;
  logic [2:0] flag_mask = '0;
  logic       restore_en = 1'b0;
  logic [2:0] restore_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [3:0] res_data;
  logic [2:0] flags_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nibble_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_mask(flag_mask),
    .restore_en(restore_en), .restore_flags(restore_flags), .out_valid(out_valid),
    .out_ready(out_ready), .res_data(res_data), .flags_out(flags_out)
  );

  // vector: pre{S,Z,C} op a b mask exp_res exp_flags
  localparam int NV = 24;
  localparam logic [24:0] VEC [NV] = '{
    {3'b100, 4'd0, 4'h7, 4'hF, 3'b111, 4'h6, 3'b001}, // R2 7+F
    {3'b100, 4'd0, 4'h8, 4'h8, 3'b111, 4'h0, 3'b011}, // R2 R7 8+8
    {3'b001, 4'd0, 4'h8, 4'hD, 3'b110, 4'h5, 3'b001}, // R10 CF kept, SF=0
    {3'b000, 4'd0, 4'h3, 4'h5, 3'b110, 4'h8, 3'b100}, // R10 SF=1
    {3'b001, 4'd1, 4'h7, 4'h8, 3'b111, 4'h0, 3'b011}, // R3
    {3'b000, 4'd1, 4'hF, 4'h0, 3'b111, 4'hF, 3'b100}, // R3
    {3'b100, 4'd2, 4'h7, 4'hF, 3'b011, 4'h8, 3'b100}, // R4 borrow
    {3'b000, 4'd2, 4'h9, 4'h9, 3'b011, 4'h0, 3'b011}, // R4 R7
    {3'b000, 4'd2, 4'h8, 4'h4, 3'b111, 4'h4, 3'b101}, // R4 SF
    {3'b000, 4'd3, 4'h5, 4'h5, 3'b011, 4'hF, 3'b000}, // R5 borrow in
    {3'b001, 4'd3, 4'h5, 4'h5, 3'b011, 4'h0, 3'b011}, // R5
    {3'b000, 4'd3, 4'h6, 4'h5, 3'b011, 4'h0, 3'b011}, // R5
    {3'b000, 4'd4, 4'h3, 4'h3, 3'b111, 4'h3, 3'b111}, // R6 equal
    {3'b111, 4'd4, 4'h2, 4'h7, 3'b111, 4'h2, 3'b000}, // R6 less
    {3'b001, 4'd5, 4'h8, 4'h0, 3'b111, 4'h1, 3'b101}, // R8 RLC
    {3'b000, 4'd5, 4'h8, 4'h0, 3'b011, 4'h0, 3'b011}, // R8 R7
    {3'b001, 4'd6, 4'h2, 4'h0, 3'b011, 4'h9, 3'b000}, // R8 RRC
    {3'b000, 4'd6, 4'h1, 4'h0, 3'b011, 4'h0, 3'b011}, // R8 R7
    {3'b001, 4'd7, 4'h5, 4'h0, 3'b101, 4'h5, 3'b100}, // R9 TCLR
    {3'b100, 4'd7, 4'h5, 4'h0, 3'b101, 4'h5, 3'b000}, // R9
    {3'b100, 4'd8, 4'hA, 4'h0, 3'b101, 4'hA, 3'b001}, // R9 TSET
    {3'b001, 4'd8, 4'h3, 4'h0, 3'b101, 4'h3, 3'b101}, // R9
    {3'b010, 4'd0, 4'hF, 4'hF, 3'b000, 4'hE, 3'b010}, // R10 empty mask
    {3'b101, 4'd9, 4'h6, 4'h3, 3'b111, 4'h6, 3'b101}  // R11
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_restore(input logic [2:0] f);
    @(negedge clk);
    restore_en = 1'b1; restore_flags = f;
    @(posedge clk);
    @(negedge clk);
    restore_en = 1'b0;
  endtask

  task automatic do_op(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b,
                       input logic [2:0] m);
    @(negedge clk);
    in_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b; flag_mask = m;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(flags_out == 3'b100, "R1 reset flags", flags_out, 3'b100);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(flags_out == 3'b100, "R1 flags after release", flags_out, 3'b100);

    for (int i = 0; i < NV; i++) begin
      do_restore(VEC[i][24:22]);
      do_op(VEC[i][21:18], VEC[i][17:14], VEC[i][13:10], VEC[i][9:7]);
      chk(out_valid && res_data == VEC[i][6:3], $sformatf("vec%0d result", i),
          res_data, VEC[i][6:3]);
      chk(flags_out == VEC[i][2:0], $sformatf("vec%0d flags", i), flags_out, VEC[i][2:0]);
    end

    // R11 reserved code 15 with full mask
    do_restore(3'b010);
    do_op(4'd15, 4'h0, 4'h0, 3'b111);
    chk(flags_out == 3'b010 && res_data == 4'h0, "R11 code15", flags_out, 3'b010);

    // R3 chain: ADC sees the carry left by the previous op
    do_restore(3'b000);
    do_op(4'd0, 4'hF, 4'h1, 3'b001);
    chk(flags_out[0] == 1'b1 && res_data == 4'h0, "R3 chain add", res_data, 0);
    do_op(4'd1, 4'h0, 4'h0, 3'b001);
    chk(res_data == 4'h1 && flags_out[0] == 1'b0, "R3 chain adc", res_data, 1);

    // R12 back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; op_code = 4'd0; opnd_a = 4'h1; opnd_b = 4'h1;
    flag_mask = 3'b000;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid && res_data == 4'h2, "R12 first result", res_data, 2);
    chk(in_ready == 1'b0, "R12 in_ready low", in_ready, 0);
    opnd_a = 4'h3; opnd_b = 4'h3;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid && res_data == 4'h2, "R12 held", res_data, 2);
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R12 in_ready with drain", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && res_data == 4'h6, "R12 next accepted", res_data, 6);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 drained", out_valid, 0);

    // R13 restore collides with an operation
    do_restore(3'b000);
    @(negedge clk);
    restore_en = 1'b1; restore_flags = 3'b110;
    in_valid = 1'b1; op_code = 4'd0; opnd_a = 4'h9; opnd_b = 4'h9; flag_mask = 3'b111;
    @(posedge clk);
    @(negedge clk);
    restore_en = 1'b0; in_valid = 1'b0;
    chk(flags_out == 3'b110, "R13 restore wins", flags_out, 3'b110);
    chk(out_valid && res_data == 4'h2, "R13 result kept", res_data, 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule